// File: doc/BRIEF.md
# Probe-Flag Single-Slot Message Channel

This block carries messages, one at a time, from one sending controller to one receiving controller through a one-word data slot. A one-bit pending flag marks whether the slot holds a message that has not been read. Each side is started by a single-cycle pulse and reports completion with a single-cycle done pulse. The block does not use a valid/ready queue. Each side runs a polling loop that tests the pending flag, and it waits a fixed tick of `TICK_CYCLES` clocks whenever it must retry.

A send request captures the word on `snd_data` in its start cycle. The sender then tests the flag until it finds the slot empty. It writes the slot, raises the flag and pulses `snd_done`. A receive request tests the flag until the slot is full. The receiver then copies the slot to `rcv_data`, lowers the flag and pulses `rcv_done`. Each of the two assignment steps (slot write or copy, and the flag update) lasts `ASSIGN_CYCLES` clocks, which models evaluation plus latch time.

The sender runs through the states SND_IDLE, SND_TEST, SND_TICK, SND_WRITE, SND_RAISE and SND_DONE:
- IDLE goes to TEST on a start pulse.
- TEST goes to TICK if the flag is set, and to WRITE if it is clear.
- TICK goes back to TEST when its count expires.
- WRITE goes to RAISE, RAISE goes to DONE, and DONE goes to IDLE.

The receiver mirrors this with RCV_IDLE, RCV_TEST, RCV_TICK, RCV_COPY, RCV_LOWER and RCV_DONE. Its TEST state goes to TICK when the flag is clear and to COPY when it is set.

Top module: `probe_channel`

## Requirements
In the requirements below, L = `ASSIGN_CYCLES`, T = `TICK_CYCLES`, and a start pulse is high in cycle n.

- R1: After reset, `msg_pending`, `snd_done` and `rcv_done` are 0 and `rcv_data` is 0. The slot is empty.
- R2: The sender tests the flag in cycle n+1. If the flag is clear, `snd_done` is high in cycle n+2+2L.
- R3: If the sender's test finds the flag set, the sender waits T cycles and tests again. Its tests fall in cycles n+1+j(T+1), and it writes only after a test finds the flag clear. Its done pulse comes 1+2L cycles after that test.
- R4: `msg_pending` rises in the same cycle that `snd_done` is high.
- R5: If the receiver's test in cycle n+1 finds the flag set, then `rcv_data` shows the message from cycle n+2+L onward. In cycle n+2+2L, `rcv_done` is high and `msg_pending` is 0.
- R6: If the receiver's test finds the flag clear, it waits T cycles and tests again, in cycles n+1+j(T+1). Its done pulse comes 1+2L cycles after the first test that finds the flag set.
- R7: A start pulse is accepted only in the idle state. A start pulse, with its data, that arrives while that side is busy has no effect.
- R8: Messages arrive at `rcv_data` in the order they were sent, with none lost and none repeated.
- R9: Every done pulse is exactly one cycle wide, and each request produces exactly one.
- R10: The slot is never written while `msg_pending` is 1, and the flag is never set and cleared in the same cycle.
- R11: Each test decides its branch from the flag value in that cycle alone. A later change of the flag by the other side does not alter or split the path already taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| snd_start | input | 1 | Single-cycle send request |
| snd_data | input | DATA_W | Message word, captured with `snd_start` |
| snd_done | output | 1 | Single-cycle send completion |
| rcv_start | input | 1 | Single-cycle receive request |
| rcv_data | output | DATA_W | Last message copied out of the slot |
| rcv_done | output | 1 | Single-cycle receive completion |
| msg_pending | output | 1 | Pending flag: the slot holds an unread message |

## Verification
With the default values (T=2, L=1), a request that succeeds on its first test ends 4 cycles after its start cycle, and each failed test adds 3 cycles. The bench records the cycle of every start pulse and of every done pulse. It predicts each done cycle from the other side's flag-change cycle, taken as the first test cycle of the form start+1+3j that is not earlier than that change. It then compares the recorded and predicted cycles exactly. Inputs change on the falling edge, and the outputs are sampled on the falling edge of the cycle being predicted. A sweep over start offsets from -6 to +6 covers the cases where the sender starts first, the receiver starts first, and both start together.

// File: rtl/chan_pkg.sv
package chan_pkg;

    typedef enum logic [2:0] {
        SND_IDLE,
        SND_TEST,
        SND_TICK,
        SND_WRITE,
        SND_RAISE,
        SND_DONE
    } snd_state_t;

    typedef enum logic [2:0] {
        RCV_IDLE,
        RCV_TEST,
        RCV_TICK,
        RCV_COPY,
        RCV_LOWER,
        RCV_DONE
    } rcv_state_t;

    // Width of a down-counter that must hold the larger of two reload values.
    function automatic int unsigned wait_cnt_width(input int unsigned a, input int unsigned b);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m < 2) ? 1 : $clog2(m);
    endfunction

endpackage

// File: rtl/chan_slot.sv
module chan_slot #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              flag_set_i,
    input  logic              flag_clr_i,
    output logic [DATA_W-1:0] slot_o,
    output logic              flag_o
);

    logic [DATA_W-1:0] slot_q;
    logic              flag_q;

    // Message word: written only by the sender.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (wr_en_i) begin
            slot_q <= wr_data_i;
        end
    end

    // Pending flag: the sender raises it, the receiver lowers it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (flag_set_i) begin
            flag_q <= 1'b1;
        end else if (flag_clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign slot_o = slot_q;
    assign flag_o = flag_q;

endmodule

// File: rtl/chan_send_ctl.sv
module chan_send_ctl
    import chan_pkg::*;
#(
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned TICK_CYCLES   = 2,
    parameter int unsigned ASSIGN_CYCLES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              flag_i,
    output logic              done_o,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              flag_set_o
);

    localparam int unsigned CW = wait_cnt_width(TICK_CYCLES, ASSIGN_CYCLES);
    localparam logic [CW-1:0] TICK_LOAD   = CW'(TICK_CYCLES - 1);
    localparam logic [CW-1:0] ASSIGN_LOAD = CW'(ASSIGN_CYCLES - 1);

    snd_state_t        state, state_nx;
    logic [CW-1:0]     cnt, cnt_nx;
    logic [DATA_W-1:0] hold, hold_nx;
    logic              cnt_zero;

    assign cnt_zero = (cnt == '0);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SND_IDLE;
            cnt   <= '0;
            hold  <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            hold  <= hold_nx;
        end
    end

    // Next state.
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        hold_nx  = hold;
        unique case (state)
            SND_IDLE: begin
                if (start_i) begin
                    state_nx = SND_TEST;
                    hold_nx  = data_i;
                end
            end
            SND_TEST: begin
                // The branch is fixed here, from this cycle's flag alone.
                if (flag_i) begin
                    state_nx = SND_TICK;
                    cnt_nx   = TICK_LOAD;
                end else begin
                    state_nx = SND_WRITE;
                    cnt_nx   = ASSIGN_LOAD;
                end
            end
            SND_TICK: begin
                if (cnt_zero) state_nx = SND_TEST;
                else          cnt_nx   = cnt - 1'b1;
            end
            SND_WRITE: begin
                if (cnt_zero) begin
                    state_nx = SND_RAISE;
                    cnt_nx   = ASSIGN_LOAD;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            SND_RAISE: begin
                if (cnt_zero) state_nx = SND_DONE;
                else          cnt_nx   = cnt - 1'b1;
            end
            SND_DONE: state_nx = SND_IDLE;
            default:  state_nx = SND_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        done_o     = 1'b0;
        wr_en_o    = 1'b0;
        flag_set_o = 1'b0;
        wr_data_o  = hold;
        unique case (state)
            SND_WRITE: wr_en_o    = cnt_zero;
            SND_RAISE: flag_set_o = cnt_zero;
            SND_DONE:  done_o     = 1'b1;
            SND_IDLE, SND_TEST, SND_TICK: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/chan_recv_ctl.sv
module chan_recv_ctl
    import chan_pkg::*;
#(
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned TICK_CYCLES   = 2,
    parameter int unsigned ASSIGN_CYCLES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              flag_i,
    input  logic [DATA_W-1:0] slot_i,
    output logic              done_o,
    output logic              flag_clr_o,
    output logic [DATA_W-1:0] data_o
);

    localparam int unsigned CW = wait_cnt_width(TICK_CYCLES, ASSIGN_CYCLES);
    localparam logic [CW-1:0] TICK_LOAD   = CW'(TICK_CYCLES - 1);
    localparam logic [CW-1:0] ASSIGN_LOAD = CW'(ASSIGN_CYCLES - 1);

    rcv_state_t        state, state_nx;
    logic [CW-1:0]     cnt, cnt_nx;
    logic [DATA_W-1:0] data_q;
    logic              cnt_zero;
    logic              copy_en;

    assign cnt_zero = (cnt == '0);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RCV_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // Destination word.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (copy_en) begin
            data_q <= slot_i;
        end
    end

    // Next state.
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            RCV_IDLE: begin
                if (start_i) state_nx = RCV_TEST;
            end
            RCV_TEST: begin
                if (!flag_i) begin
                    state_nx = RCV_TICK;
                    cnt_nx   = TICK_LOAD;
                end else begin
                    state_nx = RCV_COPY;
                    cnt_nx   = ASSIGN_LOAD;
                end
            end
            RCV_TICK: begin
                if (cnt_zero) state_nx = RCV_TEST;
                else          cnt_nx   = cnt - 1'b1;
            end
            RCV_COPY: begin
                if (cnt_zero) begin
                    state_nx = RCV_LOWER;
                    cnt_nx   = ASSIGN_LOAD;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            RCV_LOWER: begin
                if (cnt_zero) state_nx = RCV_DONE;
                else          cnt_nx   = cnt - 1'b1;
            end
            RCV_DONE: state_nx = RCV_IDLE;
            default:  state_nx = RCV_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        done_o     = 1'b0;
        flag_clr_o = 1'b0;
        copy_en    = 1'b0;
        unique case (state)
            RCV_COPY:  copy_en    = cnt_zero;
            RCV_LOWER: flag_clr_o = cnt_zero;
            RCV_DONE:  done_o     = 1'b1;
            RCV_IDLE, RCV_TEST, RCV_TICK: ;
            default: ;
        endcase
    end

    assign data_o = data_q;

endmodule

// File: rtl/probe_channel.sv
module probe_channel #(
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned TICK_CYCLES   = 2,
    parameter int unsigned ASSIGN_CYCLES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snd_start,
    input  logic [DATA_W-1:0] snd_data,
    output logic              snd_done,
    input  logic              rcv_start,
    output logic [DATA_W-1:0] rcv_data,
    output logic              rcv_done,
    output logic              msg_pending
);

    logic              w_buf_we;
    logic [DATA_W-1:0] w_buf_wdata;
    logic [DATA_W-1:0] w_slot;
    logic              w_flag;
    logic              w_flag_set;
    logic              w_flag_clr;

    chan_slot #(.DATA_W(DATA_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (w_buf_we),
        .wr_data_i  (w_buf_wdata),
        .flag_set_i (w_flag_set),
        .flag_clr_i (w_flag_clr),
        .slot_o     (w_slot),
        .flag_o     (w_flag)
    );

    chan_send_ctl #(
        .DATA_W        (DATA_W),
        .TICK_CYCLES   (TICK_CYCLES),
        .ASSIGN_CYCLES (ASSIGN_CYCLES)
    ) u_send (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (snd_start),
        .data_i     (snd_data),
        .flag_i     (w_flag),
        .done_o     (snd_done),
        .wr_en_o    (w_buf_we),
        .wr_data_o  (w_buf_wdata),
        .flag_set_o (w_flag_set)
    );

    chan_recv_ctl #(
        .DATA_W        (DATA_W),
        .TICK_CYCLES   (TICK_CYCLES),
        .ASSIGN_CYCLES (ASSIGN_CYCLES)
    ) u_recv (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (rcv_start),
        .flag_i     (w_flag),
        .slot_i     (w_slot),
        .done_o     (rcv_done),
        .flag_clr_o (w_flag_clr),
        .data_o     (rcv_data)
    );

    assign msg_pending = w_flag;

endmodule

// File: rtl/chan_checker.sv
module chan_checker (
    input logic clk,
    input logic rst_n,
    input logic snd_done,
    input logic rcv_done,
    input logic msg_pending,
    input logic buf_we,
    input logic flag_set,
    input logic flag_clr
);

    assert_snd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        snd_done |=> !snd_done);

    assert_rcv_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_done |=> !rcv_done);

    assert_pending_at_send_R4: assert property (@(posedge clk) disable iff (!rst_n)
        snd_done |-> msg_pending);

    assert_empty_at_recv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_done |-> !msg_pending);

    assert_no_overwrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_we && msg_pending));

    assert_set_clr_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_set && flag_clr));

    assert_rise_from_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_pending) |-> $past(flag_set));

endmodule

bind probe_channel chan_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .snd_done    (snd_done),
    .rcv_done    (rcv_done),
    .msg_pending (msg_pending),
    .buf_we      (w_buf_we),
    .flag_set    (w_flag_set),
    .flag_clr    (w_flag_clr)
);

// File: tb/tb_probe_channel.sv
module tb_probe_channel;

    localparam int T = 2;
    localparam int L = 1;
    localparam int P = T + 1;
    localparam int A = 2 + 2 * L;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       snd_start = 1'b0;
    logic [7:0] snd_data = '0;
    logic       snd_done;
    logic       rcv_start = 1'b0;
    logic [7:0] rcv_data;
    logic       rcv_done;
    logic       msg_pending;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int snd_cnt = 0, rcv_cnt = 0, snd_cyc = 0, rcv_cyc = 0;
    int last_sc = 0, last_rc = 0;
    logic pend_at_snd = 1'b0, pend_at_rcv = 1'b1;
    logic [7:0] got [0:63];

    always #5 clk = ~clk;

    probe_channel dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .snd_start   (snd_start),
        .snd_data    (snd_data),
        .snd_done    (snd_done),
        .rcv_start   (rcv_start),
        .rcv_data    (rcv_data),
        .rcv_done    (rcv_done),
        .msg_pending (msg_pending)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (snd_done) begin
                snd_cnt++;
                snd_cyc = cyc;
                pend_at_snd = msg_pending;
            end
            if (rcv_done) begin
                got[rcv_cnt % 64] = rcv_data;
                rcv_cnt++;
                rcv_cyc = cyc;
                pend_at_rcv = msg_pending;
            end
        end
    end

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int first_test(input int start, input int ready);
        int t = start + 1;
        while (t < ready) t += P;
        return t;
    endfunction

    task automatic send_pulse(input logic [7:0] v);
        @(negedge clk);
        snd_data  = v;
        snd_start = 1'b1;
        last_sc   = cyc;
        @(negedge clk);
        snd_start = 1'b0;
    endtask

    task automatic rcv_pulse();
        @(negedge clk);
        rcv_start = 1'b1;
        last_rc   = cyc;
        @(negedge clk);
        rcv_start = 1'b0;
    endtask

    task automatic wait_snd(input int n);
        int guard = 0;
        while (snd_cnt < n && guard < 400) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic wait_rcv(input int n);
        int guard = 0;
        while (rcv_cnt < n && guard < 400) begin
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int sc, rc, s0, r0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_eq("R1 pending", int'(msg_pending), 0);
        check_eq("R1 snd_done", int'(snd_done), 0);
        check_eq("R1 rcv_done", int'(rcv_done), 0);
        check_eq("R1 rcv_data", int'(rcv_data), 0);

        // Sender first into an empty slot
        send_pulse(8'hA5);
        sc = last_sc;
        wait_snd(1);
        check_eq("R2 snd done cycle", snd_cyc, sc + A);
        check_eq("R4 pending at snd_done", int'(pend_at_snd), 1);
        repeat (5) @(negedge clk);
        check_eq("R4 pending holds", int'(msg_pending), 1);
        rcv_pulse();
        rc = last_rc;
        wait_rcv(1);
        check_eq("R5 rcv done cycle", rcv_cyc, rc + A);
        check_eq("R5 data", int'(got[0]), 8'hA5);
        check_eq("R5 pending cleared", int'(pend_at_rcv), 0);

        // Receiver first: polls until the message lands
        repeat (3) @(negedge clk);
        rcv_pulse();
        rc = last_rc;
        repeat (4) @(negedge clk);
        send_pulse(8'h3C);
        sc = last_sc;
        wait_snd(2);
        wait_rcv(2);
        check_eq("R2 snd done with waiting receiver", snd_cyc, sc + A);
        check_eq("R6 rcv done after polling", rcv_cyc, first_test(rc, sc + A) + 1 + 2 * L);
        check_eq("R6 data", int'(got[1]), 8'h3C);

        // Sender blocked by a full slot; a second start while busy is ignored
        repeat (3) @(negedge clk);
        send_pulse(8'h11);
        wait_snd(3);
        send_pulse(8'h22);
        sc = last_sc;
        repeat (2) @(negedge clk);
        send_pulse(8'hEE);
        snd_data = 8'h77;
        repeat (10) @(negedge clk);
        check_eq("R3 sender still waiting", snd_cnt, 3);
        rcv_pulse();
        rc = last_rc;
        wait_rcv(3);
        check_eq("R10 first message not overwritten", int'(got[2]), 8'h11);
        wait_snd(4);
        check_eq("R3 blocked sender done cycle", snd_cyc, first_test(sc, rc + A) + 1 + 2 * L);
        repeat (3) @(negedge clk);
        rcv_pulse();
        wait_rcv(4);
        check_eq("R7 busy start data ignored", int'(got[3]), 8'h22);
        repeat (20) @(negedge clk);
        check_eq("R7 busy start made no extra send", snd_cnt, 4);
        check_eq("R7 slot empty afterwards", int'(msg_pending), 0);

        // Sweep of start offsets between sender and receiver
        for (int d = -6; d <= 6; d++) begin
            int ds = (d > 0) ? d : 0;
            int dr = (d < 0) ? -d : 0;
            logic [7:0] val = 8'((d + 6) * 29 + 101);
            s0 = snd_cnt;
            r0 = rcv_cnt;
            for (int i = 0; i <= 6; i++) begin
                @(negedge clk);
                snd_start = (i == ds);
                rcv_start = (i == dr);
                if (i == ds) begin
                    snd_data = val;
                    sc = cyc;
                end
                if (i == dr) rc = cyc;
            end
            @(negedge clk);
            snd_start = 1'b0;
            rcv_start = 1'b0;
            wait_snd(s0 + 1);
            wait_rcv(r0 + 1);
            repeat (4) @(negedge clk);
            check_eq("R2 sweep snd done cycle", snd_cyc, sc + A);
            check_eq("R11 sweep rcv done cycle", rcv_cyc, first_test(rc, sc + A) + 1 + 2 * L);
            check_eq("R8 sweep data", int'(got[r0 % 64]), int'(val));
            check_eq("R9 one snd_done per request", snd_cnt, s0 + 1);
            check_eq("R9 one rcv_done per request", rcv_cnt, r0 + 1);
        end

        // Back-to-back stream: order preserved
        s0 = snd_cnt;
        r0 = rcv_cnt;
        fork
            begin
                for (int i = 0; i < 6; i++) begin
                    send_pulse(8'(i * 41 + 7));
                    wait_snd(s0 + i + 1);
                end
            end
            begin
                for (int i = 0; i < 6; i++) begin
                    rcv_pulse();
                    wait_rcv(r0 + i + 1);
                end
            end
        join
        repeat (4) @(negedge clk);
        check_eq("R8 stream count", rcv_cnt, r0 + 6);
        for (int i = 0; i < 6; i++) begin
            check_eq("R8 stream order", int'(got[(r0 + i) % 64]), (i * 41 + 7) % 256);
        end
        check_eq("R8 stream slot empty", int'(msg_pending), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule